// File: doc/BRIEF.md
# Serial Command Steering Decoder

This block sits between a host's 3-wire serial port (shift clock, data, frame enable) and four downstream serially programmed targets: a local register bank, two analog front-end converters and a timing-generator chip. Every host frame opens with a 3-bit target code, sent most significant bit first. The block strips that code and hands the rest of the frame to the chosen target. The targets share one output shift clock and one data line, and each has its own load strobe. Frames that carry a code no target owns are swallowed. The targets never see a clock edge or a strobe from such a frame.

A second source, the power-up default programmer, can take over the same output lines at any time. While it is active it owns the lines outright and host traffic is ignored. The host path can only reach the live target registers and never reaches the default sequence. All host lines are sampled in the system clock domain, so the serial clock must be several times slower than the system clock.

Top module: `cmd_steer`

## Requirements
- R1: Target code 0 drives `tgt_load[0]` (local register bank), code 1 drives `tgt_load[1]` (front-end converter 1), code 2 drives `tgt_load[2]` (front-end converter 2) and code 3 drives `tgt_load[3]` (timing-generator chip). The index of the strobe equals the code.
- R2: While `frame_en` is high, the first three rising edges of `ser_clk` each sample `ser_data` into the target code, most significant bit first. During this select phase `tgt_sclk`, `tgt_sdata` and `tgt_load` stay low.
- R3: After the third code bit, the block waits until `ser_clk` is seen low. From then on the selected strobe is high and `tgt_sclk` and `tgt_sdata` follow `ser_clk` and `ser_data` in the same cycle. The target sees exactly the payload bits, in order, with no extra clock edge.
- R4: Codes 4 to 7 are reserved. For the rest of such a frame no strobe rises and `tgt_sclk` and `tgt_sdata` stay low.
- R5: Taking `frame_en` low ends the frame. The strobe falls in the same cycle, the captured code is cleared, and the next frame starts a fresh select phase.
- R6: While `dflt_active` is high, `tgt_sclk`, `tgt_sdata` and `tgt_load` equal `dflt_sclk`, `dflt_sdata` and `dflt_load`, whatever the host lines do. Host frames sent before or after never alter what the default sequence delivers.
- R7: If `dflt_active` rises during a host frame, that frame is dropped for good. After `dflt_active` falls, no host frame is accepted until `frame_en` has been seen low.
- R8: Out of reset all outputs are low, and the host path never raises more than one strobe at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_en | input | 1 | Host frame enable, active high |
| ser_clk | input | 1 | Host serial shift clock |
| ser_data | input | 1 | Host serial data |
| dflt_active | input | 1 | Default programmer owns the output lines |
| dflt_sclk | input | 1 | Default programmer shift clock |
| dflt_sdata | input | 1 | Default programmer data |
| dflt_load | input | N_TGT | Default programmer per-target strobes |
| tgt_sclk | output | 1 | Shared target shift clock |
| tgt_sdata | output | 1 | Shared target data |
| tgt_load | output | N_TGT | Per-target load strobes, active high |

## Verification
The bench builds the block with its defaults, SEL_W = 3 and N_TGT = 4. With these values half of the code space is reserved, so codes 4 to 7 can be driven to show that no strobe rises and no clock edge leaks. With four live targets, every strobe index gets a frame of its own, each with a different payload length. The scoreboard rebuilds every frame from the output pins and compares it with the queued expectation. A default-programmer burst is issued in the middle of a host select phase, while the host lines keep toggling, to show that the interrupted host frame is lost and that the default data arrives intact.

// File: rtl/cmd_steer_pkg.sv
`timescale 1ns/1ps
// Shared types for the serial command steering decoder.
// Assumes nothing beyond the standard language.
package cmd_steer_pkg;

    // Frame tracker states
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,   // no host frame open
        ST_SEL   = 3'd1,   // shifting in target code
        ST_ARM   = 3'd2,   // code complete, waiting for serial clock low
        ST_PASS  = 3'd3,   // routing payload to a live target
        ST_DROP  = 3'd4,   // reserved code, frame swallowed
        ST_BLOCK = 3'd5    // default programmer took over, frame lost
    } fr_state_e;

    // Target indices (strobe position equals target code)
    localparam int TGT_LOCAL = 0;
    localparam int TGT_AFE1  = 1;
    localparam int TGT_AFE2  = 2;
    localparam int TGT_TGEN  = 3;

endpackage

// File: rtl/cmd_steer_edge.sv
`timescale 1ns/1ps
// Rising-edge detector for the host serial clock.
// Assumes ser_clk is already synchronous to clk and toggles slower than clk.
module cmd_steer_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    output logic rise
);

    logic sclk_q;

    // Remember the previous serial clock level
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_in;
    end

    assign rise = sclk_in & ~sclk_q;

endmodule

// File: rtl/cmd_steer_frame.sv
`timescale 1ns/1ps
// Frame tracker: captures the target code MSB first and walks the frame
// through select, arm, pass/drop and block states.
// Assumes frame_en rises at least one clk cycle before the first ser_clk rise.
module cmd_steer_frame
    import cmd_steer_pkg::*;
#(
    parameter int SEL_W = 3,
    parameter int N_TGT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_en,
    input  logic             sclk,
    input  logic             sdata,
    input  logic             rise,
    input  logic             dflt_active,
    output fr_state_e        state,
    output logic [SEL_W-1:0] sel
);

    localparam int CNT_W = $clog2(SEL_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(SEL_W - 1);

    logic [CNT_W-1:0] cnt;
    logic             code_ok;

    // Code belongs to a live target
    always_comb code_ok = (int'(sel) < N_TGT);

    // Frame state, code shifter and bit counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            sel   <= '0;
            cnt   <= '0;
        end else if (dflt_active) begin
            state <= ST_BLOCK;
            sel   <= '0;
            cnt   <= '0;
        end else if (!frame_en) begin
            state <= ST_IDLE;
            sel   <= '0;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (state != ST_BLOCK) state <= ST_SEL;
                    sel <= '0;
                    cnt <= '0;
                end
                ST_SEL: begin
                    if (rise) begin
                        sel <= SEL_W'({sel, sdata});
                        cnt <= cnt + 1'b1;
                        if (cnt == LAST_BIT) state <= ST_ARM;
                    end
                end
                ST_ARM: begin
                    if (!sclk) state <= code_ok ? ST_PASS : ST_DROP;
                end
                default: state <= state;   // PASS, DROP, BLOCK hold until frame ends
            endcase
        end
    end

    // R1: a routed frame always carries a live target code
    a_r1_pass_code_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PASS) |-> (int'(sel) < N_TGT));

    // R3: routing starts only after the serial clock was seen low
    a_r3_clean_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PASS && $past(state) == ST_ARM) |-> !$past(sclk));

    // R5: frame enable low closes the frame on the next cycle
    a_r5_end_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_en && !dflt_active) |=> (state == ST_IDLE && sel == '0));

endmodule

// File: rtl/cmd_steer_route.sv
`timescale 1ns/1ps
// Output router: decodes the captured code into per-target strobes, gates the
// shared clock and data, and gives the default programmer priority.
// Assumes state and sel come from the frame tracker.
module cmd_steer_route
    import cmd_steer_pkg::*;
#(
    parameter int SEL_W = 3,
    parameter int N_TGT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  fr_state_e        state,
    input  logic [SEL_W-1:0] sel,
    input  logic             frame_en,
    input  logic             ser_clk,
    input  logic             ser_data,
    input  logic             dflt_active,
    input  logic             dflt_sclk,
    input  logic             dflt_sdata,
    input  logic [N_TGT-1:0] dflt_load,
    output logic             tgt_sclk,
    output logic             tgt_sdata,
    output logic [N_TGT-1:0] tgt_load
);

    logic             host_live;
    logic [N_TGT-1:0] host_load;

    // Host path is live only in the pass state with the frame still open
    always_comb host_live = (state == ST_PASS) && frame_en;

    // One strobe decoder per target
    for (genvar g = 0; g < N_TGT; g++) begin : g_dec
        assign host_load[g] = host_live && (sel == SEL_W'(g));
    end

    // Default programmer wins the shared lines
    always_comb begin
        if (dflt_active) begin
            tgt_sclk  = dflt_sclk;
            tgt_sdata = dflt_sdata;
            tgt_load  = dflt_load;
        end else begin
            tgt_sclk  = host_live & ser_clk;
            tgt_sdata = host_live & ser_data;
            tgt_load  = host_load;
        end
    end

    // R8: host path raises at most one strobe
    a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !dflt_active |-> $onehot0(tgt_load));

    // R2 / R4: outside routing the host path keeps the target lines quiet
    a_r2_quiet_lines: assert property (@(posedge clk) disable iff (!rst_n)
        (!dflt_active && state != ST_PASS) |-> (!tgt_sclk && !tgt_sdata && tgt_load == '0));

endmodule

// File: rtl/cmd_steer.sv
`timescale 1ns/1ps
// Serial command steering decoder, top level.
// Strips a target code from each host serial frame and steers the payload to
// one of N_TGT targets on shared clock/data with one strobe per target.
// Assumes host lines are synchronous to clk and much slower than it.
module cmd_steer
    import cmd_steer_pkg::*;
#(
    parameter int SEL_W = 3,
    parameter int N_TGT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_en,
    input  logic             ser_clk,
    input  logic             ser_data,
    input  logic             dflt_active,
    input  logic             dflt_sclk,
    input  logic             dflt_sdata,
    input  logic [N_TGT-1:0] dflt_load,
    output logic             tgt_sclk,
    output logic             tgt_sdata,
    output logic [N_TGT-1:0] tgt_load
);

    logic             rise;
    fr_state_e        state;
    logic [SEL_W-1:0] sel;

    cmd_steer_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_in (ser_clk),
        .rise    (rise)
    );

    cmd_steer_frame #(.SEL_W(SEL_W), .N_TGT(N_TGT)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_en    (frame_en),
        .sclk        (ser_clk),
        .sdata       (ser_data),
        .rise        (rise),
        .dflt_active (dflt_active),
        .state       (state),
        .sel         (sel)
    );

    cmd_steer_route #(.SEL_W(SEL_W), .N_TGT(N_TGT)) u_route (
        .clk         (clk),
        .rst_n       (rst_n),
        .state       (state),
        .sel         (sel),
        .frame_en    (frame_en),
        .ser_clk     (ser_clk),
        .ser_data    (ser_data),
        .dflt_active (dflt_active),
        .dflt_sclk   (dflt_sclk),
        .dflt_sdata  (dflt_sdata),
        .dflt_load   (dflt_load),
        .tgt_sclk    (tgt_sclk),
        .tgt_sdata   (tgt_sdata),
        .tgt_load    (tgt_load)
    );

endmodule

// File: tb/cmd_steer_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected target frames, a monitor
// rebuilds frames from the output pins and compares them.
module cmd_steer_tb;

    localparam int N = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_en = 1'b0, ser_clk = 1'b0, ser_data = 1'b0;
    logic dflt_active = 1'b0, dflt_sclk = 1'b0, dflt_sdata = 1'b0;
    logic [N-1:0] dflt_load = '0;
    logic tgt_sclk, tgt_sdata;
    logic [N-1:0] tgt_load;

    always #2.5 clk = ~clk;   // 200 MHz

    cmd_steer u_dut (
        .clk(clk), .rst_n(rst_n), .frame_en(frame_en), .ser_clk(ser_clk),
        .ser_data(ser_data), .dflt_active(dflt_active), .dflt_sclk(dflt_sclk),
        .dflt_sdata(dflt_sdata), .dflt_load(dflt_load), .tgt_sclk(tgt_sclk),
        .tgt_sdata(tgt_sdata), .tgt_load(tgt_load)
    );

    typedef struct {
        logic [N-1:0] loads;
        logic [31:0]  data;
        int           nbits;
        int           req;
    } item_t;

    item_t exp_q[$];
    item_t e_cur;
    int nchk = 0, nfail = 0, stray = 0;
    bit done = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: rebuild frames from the target pins
    logic [N-1:0] m_loads = '0;
    logic [31:0]  m_data = '0;
    int           m_n = 0;
    logic         m_in = 1'b0, m_prev = 1'b0;
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            if (tgt_load != '0) begin
                if (!m_in) begin
                    m_in = 1'b1; m_loads = '0; m_data = '0; m_n = 0; m_prev = tgt_sclk;
                end
                m_loads |= tgt_load;
                if (tgt_sclk && !m_prev) begin
                    m_data = {m_data[30:0], tgt_sdata};
                    m_n++;
                end
                m_prev = tgt_sclk;
            end else begin
                if (m_in) begin
                    m_in = 1'b0;
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R4 unexpected frame", int'(m_loads), 0);
                    end else begin
                        e_cur = exp_q.pop_front();
                        nchk++;
                        if (m_loads != e_cur.loads || m_data != e_cur.data || m_n != e_cur.nbits) begin
                            nfail++;
                            $display("FAIL R%0d frame actual loads=%0h data=%0h n=%0d expected loads=%0h data=%0h n=%0d",
                                     e_cur.req, m_loads, m_data, m_n, e_cur.loads, e_cur.data, e_cur.nbits);
                        end
                    end
                end
                // R2 / R4: quiet lines whenever no strobe is up on the host path
                if (!dflt_active && (tgt_sclk || tgt_sdata)) stray++;
            end
        end
    end

    task automatic ser_bit(input logic b);
        ser_data = b; ser_clk = 1'b0;
        repeat (2) @(negedge clk);
        ser_clk = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic push(input logic [N-1:0] ld, input logic [31:0] d, input int n, input int req);
        item_t it;
        it.loads = ld; it.data = d & ((32'h1 << n) - 1); it.nbits = n; it.req = req;
        exp_q.push_back(it);
    endtask

    // Driver: one complete host frame (R1 code map, R3 payload, R5 end)
    task automatic send_host(input logic [2:0] code, input logic [31:0] d, input int n, input int req);
        if (code < 3'd4) push(N'(1) << code, d, n, req);
        frame_en = 1'b1;
        @(negedge clk);
        for (int i = 2; i >= 0; i--) ser_bit(code[i]);
        for (int i = n - 1; i >= 0; i--) ser_bit(d[i]);
        ser_clk = 1'b0; ser_data = 1'b0;
        repeat (2) @(negedge clk);
        frame_en = 1'b0;
        #1 check(tgt_load == '0, "R5 strobe drop", int'(tgt_load), 0);
        repeat (3) @(negedge clk);
    endtask

    // Driver: one default-programmer burst (R6)
    task automatic send_dflt(input logic [N-1:0] ld, input logic [31:0] d, input int n);
        push(ld, d, n, 6);
        dflt_active = 1'b1;
        @(negedge clk);
        dflt_load = ld;
        for (int i = n - 1; i >= 0; i--) begin
            dflt_sdata = d[i]; dflt_sclk = 1'b0;
            repeat (2) @(negedge clk);
            dflt_sclk = 1'b1;
            repeat (2) @(negedge clk);
        end
        dflt_sclk = 1'b0; dflt_sdata = 1'b0;
        @(negedge clk);
        dflt_load = '0;
        repeat (2) @(negedge clk);
        dflt_active = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8: outputs low in and out of reset
        check(tgt_load == '0 && !tgt_sclk && !tgt_sdata, "R8 in reset", int'(tgt_load), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1 check(tgt_load == '0 && !tgt_sclk && !tgt_sdata, "R8 after reset", int'(tgt_load), 0);

        // R1 / R3: every live target, distinct payloads and lengths
        send_host(3'd0, 32'h0000_B6A1, 16, 1);
        send_host(3'd1, 32'h0000_03C5, 11, 1);
        send_host(3'd2, 32'h0000_005A, 8, 3);
        send_host(3'd3, 32'h00F0_0F3C, 24, 1);
        send_host(3'd2, 32'h0000_0001, 1, 3);

        // R4: reserved codes swallowed
        send_host(3'd4, 32'h0000_FFFF, 16, 4);
        send_host(3'd5, 32'h0000_00FF, 8, 4);
        send_host(3'd6, 32'h0000_0AAA, 12, 4);
        send_host(3'd7, 32'h0000_FFFF, 16, 4);

        // R5: back-to-back frames each restart the select phase
        send_host(3'd1, 32'h0000_0099, 8, 5);
        send_host(3'd3, 32'h0000_0066, 8, 5);

        // R6: default burst delivered intact while host lines toggle
        fork
            send_dflt(4'b0100, 32'h0000_A5C3, 16);
            for (int i = 0; i < 12; i++) ser_bit(i[0]);
        join
        #1 check(tgt_load == '0, "R6 lines released", int'(tgt_load), 0);

        // R7: default burst interrupts a host select phase
        frame_en = 1'b1;
        @(negedge clk);
        ser_bit(1'b0);
        ser_bit(1'b1);
        send_dflt(4'b0001, 32'h0000_1234, 16);
        ser_bit(1'b0);
        for (int i = 0; i < 8; i++) ser_bit(1'b1);
        #1 check(tgt_load == '0 && !tgt_sclk, "R7 frame dropped", int'(tgt_load), 0);
        ser_clk = 1'b0;
        repeat (2) @(negedge clk);
        frame_en = 1'b0;
        repeat (3) @(negedge clk);
        send_host(3'd2, 32'h0000_0C3A, 12, 7);

        // R6: same default content again after host writes
        send_dflt(4'b0100, 32'h0000_A5C3, 16);

        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R1 missing frames", exp_q.size(), 0);
        check(stray == 0, "R2 R4 stray activity", stray, 0);
        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

endmodule